// File: doc/BRIEF.md
# JTAG Instruction Gating Sequencer

This block sits between the instruction register of a JTAG test access port and the logic that acts on the current instruction. On each instruction-update strobe it decides whether the newly latched opcode may take effect. The decision depends on whether the on-chip configuration controller is busy, whether configuration has already completed, and whether the controller was halted by an earlier instruction. A few harmless instructions always pass, so identification and pin sampling work during a live configuration. Every other instruction is held back until configuration is stopped or has finished. A refused opcode is replaced by BYPASS.

The block drives three things. The first is a halt request that parks the configuration controller in an idle state. The second is an enable that hands the I/O buffers to the test port. The third is a pair of status flags: one shows that configuration was interrupted, and one shows that the last update was refused. Test-logic reset returns the gating state to its idle values. The chip-wide clear and output-enable inputs have no effect on the block.

Opcodes (10 bits): BYPASS 10'h3FF, IDCODE 10'h006, SAMPLE 10'h005, EXTEST 10'h00F, I/O-config 10'h00D, controller-halt 10'h2D0, controller-resume 10'h2B0. Any code not in this list counts as a general instruction.

Top module: `jtag_instr_gate`

## Requirements
- R1: On an update with BYPASS (10'h3FF), IDCODE (10'h006) or SAMPLE (10'h005), `effInstr` takes that opcode in every state. `disengageReq`, `ioOverrideEn` and `cfgInterrupted` keep their values.
- R2: General instructions (any code other than the seven listed, for example EXTEST 10'h00F) are refused in one case: `cfgBusy`=1, `cfgDone`=0 and `disengageReq`=0. A refused update makes `effInstr` 10'h3FF and sets `refused`. When `cfgBusy`=0, or when the controller is halted, a general instruction is accepted.
- R3: Controller-halt (10'h2D0) is always accepted. It sets `disengageReq`. It also sets `cfgInterrupted` when `cfgBusy`=1 and `cfgDone`=0.
- R4: I/O-config (10'h00D) is accepted only while `disengageReq`=1 or `cfgDone`=1. When accepted it sets `ioOverrideEn`. Otherwise it is refused as in R2.
- R5: An I/O-config update never changes `disengageReq`.
- R6: Controller-resume (10'h2B0) is accepted and clears `disengageReq`, `ioOverrideEn` and `cfgInterrupted`.
- R7: `chipClear` and `chipOutEn` have no effect on any output.
- R8: While `cfgDone`=1, every opcode is accepted without a prior halt.
- R9: `refused` stays set until the next accepted update, which clears it.
- R10: `rst_n` low, or `tlrst` high at a clock edge, sets `effInstr` to 10'h006 and clears `disengageReq`, `ioOverrideEn`, `cfgInterrupted` and `refused`. `tlrst` takes priority over `irUpdate`.
- R11: Outputs change on the clock edge that samples `irUpdate`=1 or `tlrst`=1, and hold at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tlrst | input | 1 | Test-logic reset from the TAP, synchronous |
| irUpdate | input | 1 | One-cycle instruction-update strobe |
| irOpcode | input | 10 | Latched instruction register contents |
| cfgBusy | input | 1 | Configuration controller is loading |
| cfgDone | input | 1 | Configuration completed successfully |
| chipClear | input | 1 | Chip-wide clear, no effect on this block |
| chipOutEn | input | 1 | Chip-wide output enable, no effect on this block |
| effInstr | output | 10 | Instruction that takes effect |
| disengageReq | output | 1 | Halt and idle request to the configuration controller |
| ioOverrideEn | output | 1 | I/O buffers under test-port control |
| cfgInterrupted | output | 1 | A running configuration was halted |
| refused | output | 1 | Last update was refused |

## Verification
The assertions check these rules on every cycle: the three safe opcodes pass unchanged, a general opcode is refused during live configuration, halt and resume move the request line, the I/O enable rises only after a halt or completion, and outputs hold with no strobe even while the chip-wide inputs toggle. Some behaviour depends on history, and only the bench's ordered scenarios show it. This includes the refused flag clearing on the next accepted update, a resume followed by a fresh refusal, and the acceptance rules changing once configuration is done or the controller is idle.

// File: rtl/jig_pkg.sv
package jig_pkg;
  localparam int IR_W = 10;

  localparam logic [IR_W-1:0] OP_BYPASS  = 10'h3FF;
  localparam logic [IR_W-1:0] OP_IDCODE  = 10'h006;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST  = 10'h00F;
  localparam logic [IR_W-1:0] OP_IOCFG   = 10'h00D;
  localparam logic [IR_W-1:0] OP_HALT    = 10'h2D0;
  localparam logic [IR_W-1:0] OP_RESUME  = 10'h2B0;

  localparam int SAFE_N = 3;
  localparam logic [IR_W-1:0] SAFE_LIST [SAFE_N] = '{OP_BYPASS, OP_IDCODE, OP_SAMPLE};

  typedef enum logic [2:0] {
    CL_SAFE,
    CL_HALT,
    CL_RESUME,
    CL_IOCFG,
    CL_OTHER
  } opClass_t;

  typedef struct packed {
    logic loadOp;
    logic loadBypass;
    logic loadIdle;
    logic setHalt;
    logic clrHalt;
    logic setIo;
    logic setIntr;
    logic setRefused;
    logic clrRefused;
  } ctlStrobe_t;
endpackage

// File: rtl/jig_classify.sv
module jig_classify
  import jig_pkg::*;
(
  input  logic [IR_W-1:0] opcode,
  output opClass_t        opClass
);
  logic [SAFE_N-1:0] safeHit;

  generate
    for (genvar i = 0; i < SAFE_N; i++) begin : g_safe
      assign safeHit[i] = (opcode == SAFE_LIST[i]);
    end
  endgenerate

  always_comb begin
    if (|safeHit)                opClass = CL_SAFE;
    else if (opcode == OP_HALT)   opClass = CL_HALT;
    else if (opcode == OP_RESUME) opClass = CL_RESUME;
    else if (opcode == OP_IOCFG)  opClass = CL_IOCFG;
    else                          opClass = CL_OTHER;
  end
endmodule

// File: rtl/jig_ctrl.sv
module jig_ctrl
  import jig_pkg::*;
(
  input  logic       irUpdate,
  input  logic       tlrst,
  input  opClass_t   opClass,
  input  logic       cfgBusy,
  input  logic       cfgDone,
  input  logic       halted,
  output ctlStrobe_t strobe
);
  logic liveCfg;
  logic accept;

  assign liveCfg = cfgBusy && !cfgDone && !halted;

  always_comb begin
    strobe = '0;
    accept = 1'b0;
    if (tlrst) begin
      strobe.loadIdle = 1'b1;
    end else if (irUpdate) begin
      unique case (opClass)
        CL_SAFE:   accept = 1'b1;
        CL_HALT: begin
          accept         = 1'b1;
          strobe.setHalt = 1'b1;
          strobe.setIntr = cfgBusy && !cfgDone;
        end
        CL_RESUME: begin
          accept         = 1'b1;
          strobe.clrHalt = 1'b1;
        end
        CL_IOCFG: begin
          accept       = halted || cfgDone;
          strobe.setIo = halted || cfgDone;
        end
        default:   accept = !liveCfg;
      endcase
      strobe.loadOp     = accept;
      strobe.clrRefused = accept;
      strobe.loadBypass = !accept;
      strobe.setRefused = !accept;
    end
  end
endmodule

// File: rtl/jig_dpath.sv
module jig_dpath
  import jig_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ctlStrobe_t      strobe,
  input  logic [IR_W-1:0] opcode,
  output logic [IR_W-1:0] effInstr,
  output logic            haltReg,
  output logic            ioReg,
  output logic            intrReg,
  output logic            refReg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      effInstr <= OP_IDCODE;
      haltReg  <= 1'b0;
      ioReg    <= 1'b0;
      intrReg  <= 1'b0;
      refReg   <= 1'b0;
    end else if (strobe.loadIdle) begin
      effInstr <= OP_IDCODE;
      haltReg  <= 1'b0;
      ioReg    <= 1'b0;
      intrReg  <= 1'b0;
      refReg   <= 1'b0;
    end else begin
      if (strobe.loadOp)     effInstr <= opcode;
      if (strobe.loadBypass) effInstr <= OP_BYPASS;
      if (strobe.setHalt)    haltReg  <= 1'b1;
      if (strobe.clrHalt) begin
        haltReg <= 1'b0;
        ioReg   <= 1'b0;
        intrReg <= 1'b0;
      end
      if (strobe.setIo)      ioReg    <= 1'b1;
      if (strobe.setIntr)    intrReg  <= 1'b1;
      if (strobe.setRefused) refReg   <= 1'b1;
      if (strobe.clrRefused) refReg   <= 1'b0;
    end
  end
endmodule

// File: rtl/jtag_instr_gate.sv
module jtag_instr_gate
  import jig_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tlrst,
  input  logic            irUpdate,
  input  logic [IR_W-1:0] irOpcode,
  input  logic            cfgBusy,
  input  logic            cfgDone,
  input  logic            chipClear,
  input  logic            chipOutEn,
  output logic [IR_W-1:0] effInstr,
  output logic            disengageReq,
  output logic            ioOverrideEn,
  output logic            cfgInterrupted,
  output logic            refused
);
  opClass_t   opClass;
  ctlStrobe_t strobe;

  jig_classify u_cls (
    .opcode  (irOpcode),
    .opClass (opClass)
  );

  jig_ctrl u_ctrl (
    .irUpdate (irUpdate),
    .tlrst    (tlrst),
    .opClass  (opClass),
    .cfgBusy  (cfgBusy),
    .cfgDone  (cfgDone),
    .halted   (disengageReq),
    .strobe   (strobe)
  );

  jig_dpath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .opcode   (irOpcode),
    .effInstr (effInstr),
    .haltReg  (disengageReq),
    .ioReg    (ioOverrideEn),
    .intrReg  (cfgInterrupted),
    .refReg   (refused)
  );
endmodule

// File: rtl/jig_checker.sv
module jig_checker
  import jig_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tlrst,
  input logic            irUpdate,
  input logic [IR_W-1:0] irOpcode,
  input logic            cfgBusy,
  input logic            cfgDone,
  input logic            chipClear,
  input logic            chipOutEn,
  input logic [IR_W-1:0] effInstr,
  input logic            disengageReq,
  input logic            ioOverrideEn,
  input logic            cfgInterrupted,
  input logic            refused
);
  logic upd;
  logic safeOp;
  assign upd    = irUpdate && !tlrst;
  assign safeOp = (irOpcode == OP_BYPASS) || (irOpcode == OP_IDCODE) || (irOpcode == OP_SAMPLE);

  p_safe_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    upd && safeOp |=> (effInstr == $past(irOpcode)) && $stable(disengageReq)
                      && $stable(ioOverrideEn) && $stable(cfgInterrupted));

  p_block_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd && (irOpcode == OP_EXTEST) && cfgBusy && !cfgDone && !disengageReq
      |=> (effInstr == OP_BYPASS) && refused);

  p_halt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd && (irOpcode == OP_HALT) |=> disengageReq && (effInstr == OP_HALT));

  p_io_after_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ioOverrideEn) |-> ($past(disengageReq) || $past(cfgDone)));

  p_io_keeps_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd && (irOpcode == OP_IOCFG) |=> $stable(disengageReq));

  p_resume_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd && (irOpcode == OP_RESUME) |=> !disengageReq && !ioOverrideEn && !cfgInterrupted);

  p_chip_inputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chipClear || chipOutEn) && !irUpdate && !tlrst
      |=> $stable(effInstr) && $stable(disengageReq) && $stable(ioOverrideEn));

  p_done_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd && cfgDone |=> !refused);

  p_tlrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tlrst |=> (effInstr == OP_IDCODE) && !disengageReq && !ioOverrideEn
              && !cfgInterrupted && !refused);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irUpdate && !tlrst |=> $stable(effInstr) && $stable(disengageReq) && $stable(ioOverrideEn)
                            && $stable(cfgInterrupted) && $stable(refused));
endmodule

bind jtag_instr_gate jig_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tlrst          (tlrst),
  .irUpdate       (irUpdate),
  .irOpcode       (irOpcode),
  .cfgBusy        (cfgBusy),
  .cfgDone        (cfgDone),
  .chipClear      (chipClear),
  .chipOutEn      (chipOutEn),
  .effInstr       (effInstr),
  .disengageReq   (disengageReq),
  .ioOverrideEn   (ioOverrideEn),
  .cfgInterrupted (cfgInterrupted),
  .refused        (refused)
);

// File: tb/jtag_instr_gate_tb.sv
`timescale 1ns/1ps
module jtag_instr_gate_tb;
  localparam logic [9:0] BYP = 10'h3FF;
  localparam logic [9:0] IDC = 10'h006;
  localparam logic [9:0] SMP = 10'h005;
  localparam logic [9:0] EXT = 10'h00F;
  localparam logic [9:0] IOC = 10'h00D;
  localparam logic [9:0] HLT = 10'h2D0;
  localparam logic [9:0] RSM = 10'h2B0;

  // {req[3:0], tlrst, busy, done, opcode[9:0], expEff[9:0], expDis, expIo, expIntr, expRef}
  localparam int NV = 21;
  localparam logic [30:0] VEC [NV] = '{
    {4'd1,  3'b010, SMP, SMP, 4'b0000},  // R1 sample during live config
    {4'd2,  3'b010, EXT, BYP, 4'b0001},  // R2 refused while live
    {4'd9,  3'b010, IDC, IDC, 4'b0000},  // R9 accepted update clears refused
    {4'd4,  3'b010, IOC, BYP, 4'b0001},  // R4 io-config without halt
    {4'd9,  3'b010, BYP, BYP, 4'b0000},  // R9 bypass accepted, refused cleared
    {4'd3,  3'b010, HLT, HLT, 4'b1010},  // R3 halt during live config
    {4'd4,  3'b010, IOC, IOC, 4'b1110},  // R4 io-config after halt, R5 halt kept
    {4'd2,  3'b010, EXT, EXT, 4'b1110},  // R2 general accepted after halt
    {4'd1,  3'b010, SMP, SMP, 4'b1110},  // R1 no disturbance
    {4'd6,  3'b010, RSM, RSM, 4'b0000},  // R6 resume clears all
    {4'd2,  3'b010, EXT, BYP, 4'b0001},  // R2 refused again after resume
    {4'd2,  3'b000, EXT, EXT, 4'b0000},  // R2 idle controller accepts general
    {4'd4,  3'b000, IOC, BYP, 4'b0001},  // R4 idle still needs halt
    {4'd8,  3'b001, IOC, IOC, 4'b0100},  // R8 done allows io-config, R5
    {4'd8,  3'b001, EXT, EXT, 4'b0100},  // R8 done allows general
    {4'd3,  3'b001, HLT, HLT, 4'b1100},  // R3 halt after done, no interrupt mark
    {4'd10, 3'b100, EXT, IDC, 4'b0000},  // R10 test-logic reset wins over update
    {4'd3,  3'b010, HLT, HLT, 4'b1010},  // R3 halt again
    {4'd2,  3'b010, 10'h155, 10'h155, 4'b1010}, // R2 arbitrary code after halt
    {4'd6,  3'b010, RSM, RSM, 4'b0000},  // R6 resume
    {4'd1,  3'b010, IDC, IDC, 4'b0000}   // R1 idcode live
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tlrst = 1'b0;
  logic       irUpdate = 1'b0;
  logic [9:0] irOpcode = '0;
  logic       cfgBusy = 1'b0;
  logic       cfgDone = 1'b0;
  logic       chipClear = 1'b0;
  logic       chipOutEn = 1'b0;
  logic [9:0] effInstr;
  logic       disengageReq, ioOverrideEn, cfgInterrupted, refused;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  jtag_instr_gate u_dut (
    .clk(clk), .rst_n(rst_n), .tlrst(tlrst), .irUpdate(irUpdate), .irOpcode(irOpcode),
    .cfgBusy(cfgBusy), .cfgDone(cfgDone), .chipClear(chipClear), .chipOutEn(chipOutEn),
    .effInstr(effInstr), .disengageReq(disengageReq), .ioOverrideEn(ioOverrideEn),
    .cfgInterrupted(cfgInterrupted), .refused(refused)
  );

  task automatic checkOut(input string tag, input logic [9:0] eEff, input logic [3:0] eFlags);
    logic [3:0] aFlags;
    aFlags = {disengageReq, ioOverrideEn, cfgInterrupted, refused};
    nChecks++;
    if (effInstr !== eEff || aFlags !== eFlags) begin
      nFails++;
      $display("FAIL %s: eff=%h flags=%b expected eff=%h flags=%b", tag, effInstr, aFlags, eEff, eFlags);
    end
  endtask

  task automatic pulse(input logic tl, input logic up, input logic [9:0] op);
    @(negedge clk);
    tlrst = tl; irUpdate = up; irOpcode = op;
    @(negedge clk);
    tlrst = 1'b0; irUpdate = 1'b0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    checkOut("R10 reset", IDC, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      string tag;
      v = VEC[i];
      cfgBusy = v[25]; cfgDone = v[24];
      pulse(v[26], 1'b1, v[23:14]);
      tag = $sformatf("R%0d row%0d", v[30:27], i);
      checkOut(tag, v[13:4], v[3:0]);
    end

    // R7: chip-wide inputs toggle with no strobe; state must hold
    cfgBusy = 1'b1; cfgDone = 1'b0;
    pulse(1'b0, 1'b1, HLT);
    pulse(1'b0, 1'b1, IOC);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chipClear = k[0]; chipOutEn = k[1];
    end
    @(negedge clk);
    checkOut("R7 chip inputs idle", IOC, 4'b1110);

    // R7: chip-wide inputs active during an update do not change its outcome
    chipClear = 1'b1; chipOutEn = 1'b1;
    pulse(1'b0, 1'b1, EXT);
    checkOut("R7 chip inputs during update", EXT, 4'b1110);
    chipClear = 1'b0; chipOutEn = 1'b0;

    // R11: opcode changes without strobe are ignored
    @(negedge clk); irOpcode = RSM;
    repeat (4) @(negedge clk);
    checkOut("R11 no strobe hold", EXT, 4'b1110);

    // R10: test-logic reset alone from a halted state
    pulse(1'b1, 1'b0, RSM);
    checkOut("R10 tlrst clears", IDC, 4'b0000);

    // R9: refused persists across idle cycles
    cfgBusy = 1'b1; cfgDone = 1'b0;
    pulse(1'b0, 1'b1, EXT);
    repeat (3) @(negedge clk);
    checkOut("R9 refused sticky", BYP, 4'b0001);

    // R3 with cfgDone high while busy: no interrupt mark
    cfgDone = 1'b1;
    pulse(1'b0, 1'b1, HLT);
    checkOut("R3 halt after done", HLT, 4'b1000);

    // R10 async reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    checkOut("R10 async reset", IDC, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule